// File: doc/BRIEF.md
# Fractional Audio Master-Clock Divider

This block derives an audio module clock from one of four source clocks and divides it by a fractional ratio N + b/a. The sources are modelled as single-cycle enable pulses in one system clock domain. N is an 8-bit integer. The numerator b and the denominator a set the fraction. Each output period lasts either N or N+1 source ticks. Within every run of a periods, the longer periods are spread evenly, so the average ratio is N + b/a and the jitter stays uniform.

There are two independent channels, one for transmit and one for receive. Each channel has its own source select, divisor, fraction and clock-on enable. A routing select chooses which of the two divided clocks drives the shared master-clock output.

A channel takes a complete new configuration only at the start of a run. Changes made in mid-run therefore never shorten or stretch the period in progress. When a channel is switched off, its output is held low. When it is switched back on, it starts a fresh run that begins with a high phase.

Top module: `mclk_frac_div`

## Requirements
- R1: The 2-bit source select picks which source tick advances a channel: 0 crystal, 1 fast PLL, 2 slow PLL, 3 external master clock. A period of L ticks lasts L times the tick spacing of the selected source.
- R2: If b = 0, a = 0 or b ≥ a, every period lasts N ticks. A run is then one period long. N values of 0 and 1 act as 2.
- R3: For 0 < b < a, each run of a periods contains exactly b periods of N+1 ticks and a−b periods of N ticks.
- R4: When 2b ≤ a, with x = ⌊(a−b)/b⌋ and y = a − b(x+1), a run is b groups of [x periods of N, then one of N+1], followed by y periods of N.
- R5: When 2b > a, with c = a−b, x = ⌊b/c⌋ and y = a − c(x+1), a run is c groups of [one period of N, then x periods of N+1], followed by y periods of N+1.
- R6: A period of L ticks is high for the first ⌊L/2⌋ ticks and low for the rest.
- R7: After reset, and from the cycle after a channel's clock-on input is low, that channel's output is low. The cycle after clock-on rises, the output is high, and a new run begins.
- R8: Changes to N, a, b or the source select while a channel runs take effect only at the start of that channel's next run.
- R9: The master-clock output follows the transmit clock when the route select is 0 and the receive clock when it is 1.
- R10: The two channels run independently, each from its own configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | One enable pulse per source clock, indexed by source code |
| tx_src_sel | input | 2 | Transmit source select |
| tx_div_int | input | 8 | Transmit integer divisor N |
| tx_frac_num | input | 6 | Transmit fraction numerator b |
| tx_frac_den | input | 6 | Transmit fraction denominator a |
| tx_clk_on | input | 1 | Transmit clock enable |
| rx_src_sel | input | 2 | Receive source select |
| rx_div_int | input | 8 | Receive integer divisor N |
| rx_frac_num | input | 6 | Receive fraction numerator b |
| rx_frac_den | input | 6 | Receive fraction denominator a |
| rx_clk_on | input | 1 | Receive clock enable |
| mclk_use_rx | input | 1 | Master-clock route: 0 transmit, 1 receive |
| tx_mclk | output | 1 | Transmit divided clock |
| rx_mclk | output | 1 | Receive divided clock |
| mclk_out | output | 1 | Routed master clock |

## Verification
The bench checks both pattern orders: a fraction below one half, a fraction above one half, and the exact half-way value b = a/2. A sequencer that picked the wrong branch at that value, or placed the odd period at the wrong end of a group, would produce periods in the wrong order even though the average ratio was right. Divisors of 0 and 1, and b ≥ a, must fall back to integer division; a design that took them literally would emit runt periods or a stuck clock. A configuration change in mid-run must leave the rest of the old run intact, which catches a design that reloads on every period. Odd period lengths expose an off-by-one in the high phase, and the slower sources expose a counter that advances on the system clock rather than on the selected tick.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;
   localparam int SRC_SEL_W = 2;
   localparam int SRC_COUNT = 1 << SRC_SEL_W;
   localparam int CHAN_CNT  = 2;

   typedef enum logic [SRC_SEL_W-1:0] {
      SRC_XTAL     = 2'd0,
      SRC_PLL_FAST = 2'd1,
      SRC_PLL_SLOW = 2'd2,
      SRC_EXT_MCLK = 2'd3
   } src_sel_e;
endpackage

// File: rtl/mclk_tick_mux.sv
module mclk_tick_mux #(
   parameter int SEL_W   = 2,
   parameter int NUM_SRC = 4
) (
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);
   if (NUM_SRC != (1 << SEL_W)) begin : g_bad_src
      $error("NUM_SRC must equal 2**SEL_W");
   end

   logic [NUM_SRC-1:0] hit;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign hit[s] = src_tick[s] && (sel == SEL_W'(s));
   end

   assign tick = |hit;
endmodule

// File: rtl/mclk_frac_seq.sv
module mclk_frac_seq #(
   parameter int DIV_W  = 8,
   parameter int FRAC_W = 6,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic [DIV_W-1:0]  n_in,
   input  logic [FRAC_W-1:0] num_in,
   input  logic [FRAC_W-1:0] den_in,
   input  logic [SEL_W-1:0]  sel_in,
   output logic [DIV_W-1:0]  n_eff,
   output logic              long_now,
   output logic [SEL_W-1:0]  sel_q
);
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("FRAC_W must be at least 1");
   end

   // configuration decoded from the live inputs, applied at a run start
   logic              frac_d, small_d;
   logic [FRAC_W-1:0] rest_d, minor_d, major_d, div_by, x_d, y_d;
   logic [DIV_W-1:0]  n_d;

   assign frac_d  = (num_in != '0) && (den_in != '0) && (num_in < den_in);
   assign rest_d  = den_in - num_in;
   assign small_d = {num_in, 1'b0} <= {1'b0, den_in};
   assign minor_d = small_d ? num_in : rest_d;
   assign major_d = small_d ? rest_d : num_in;
   assign div_by  = (minor_d == '0) ? FRAC_W'(1) : minor_d;
   assign x_d     = major_d / div_by;
   assign y_d     = den_in - minor_d * (x_d + FRAC_W'(1));
   assign n_d     = (n_in < DIV_W'(2)) ? DIV_W'(2) : n_in;

   // run state
   logic              frac_q, minor_long_q, in_tail_q;
   logic [FRAC_W-1:0] x_q, z_q, y_q, p_q, g_q, t_q;
   logic [DIV_W-1:0]  n_q;
   logic              run_end, minor_now, load_now;

   always_comb begin
      if (!frac_q)        run_end = 1'b1;
      else if (in_tail_q) run_end = (t_q == y_q - FRAC_W'(1));
      else                run_end = (p_q == x_q) && (g_q == z_q - FRAC_W'(1)) && (y_q == '0);
   end

   assign minor_now = minor_long_q ? (p_q == x_q) : (p_q == '0);
   assign long_now  = frac_q && (in_tail_q ? !minor_long_q : (minor_now == minor_long_q));
   assign load_now  = load || (adv && run_end);
   assign n_eff     = n_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_q          <= DIV_W'(2);
         sel_q        <= '0;
         frac_q       <= 1'b0;
         minor_long_q <= 1'b0;
         in_tail_q    <= 1'b0;
         x_q          <= '0;
         z_q          <= '0;
         y_q          <= '0;
         p_q          <= '0;
         g_q          <= '0;
         t_q          <= '0;
      end else if (load_now) begin
         n_q          <= n_d;
         sel_q        <= sel_in;
         frac_q       <= frac_d;
         minor_long_q <= small_d;
         in_tail_q    <= 1'b0;
         x_q          <= x_d;
         z_q          <= minor_d;
         y_q          <= y_d;
         p_q          <= '0;
         g_q          <= '0;
         t_q          <= '0;
      end else if (adv) begin
         if (in_tail_q) begin
            t_q <= t_q + FRAC_W'(1);
         end else if (p_q == x_q) begin
            p_q <= '0;
            if (g_q == z_q - FRAC_W'(1)) begin
               in_tail_q <= 1'b1;
               t_q       <= '0;
            end else begin
               g_q <= g_q + FRAC_W'(1);
            end
         end else begin
            p_q <= p_q + FRAC_W'(1);
         end
      end
   end

   // R4 / R5: group position never passes the group size or group count
   a_r4_grp_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (frac_q && !in_tail_q) |-> (p_q <= x_q && g_q < z_q));

   // R3: tail index stays inside the tail length
   a_r3_tail_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (frac_q && in_tail_q) |-> (t_q < y_q));
endmodule

// File: rtl/mclk_period_gen.sv
module mclk_period_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [DIV_W-1:0] n_eff,
   input  logic             long_now,
   output logic             adv,
   output logic             mclk
);
   localparam int LEN_W = DIV_W + 1;

   logic [LEN_W-1:0] per_len, half_len, cnt_q;
   logic             last;

   assign per_len  = {1'b0, n_eff} + LEN_W'(long_now);
   assign half_len = per_len >> 1;
   assign last     = (cnt_q == per_len - LEN_W'(1));
   assign adv      = run && tick && last;
   assign mclk     = run && (cnt_q < half_len);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt_q <= '0;
      else if (tick)      cnt_q <= last ? '0 : cnt_q + LEN_W'(1);
   end

   // R8: the tick count never exceeds the length of the period in progress
   a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < per_len);

   // R8: the period length cannot change while a period is under way
   a_r8_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> $stable(per_len));

   // R6: a rising edge only appears at a period boundary or at enable
   a_r6_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mclk) |-> ($past(adv) || $rose(run)));
endmodule

// File: rtl/mclk_frac_div.sv
module mclk_frac_div
   import mclk_div_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int FRAC_W = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SRC_COUNT-1:0] src_tick,
   input  logic [SRC_SEL_W-1:0] tx_src_sel,
   input  logic [DIV_W-1:0]     tx_div_int,
   input  logic [FRAC_W-1:0]    tx_frac_num,
   input  logic [FRAC_W-1:0]    tx_frac_den,
   input  logic                 tx_clk_on,
   input  logic [SRC_SEL_W-1:0] rx_src_sel,
   input  logic [DIV_W-1:0]     rx_div_int,
   input  logic [FRAC_W-1:0]    rx_frac_num,
   input  logic [FRAC_W-1:0]    rx_frac_den,
   input  logic                 rx_clk_on,
   input  logic                 mclk_use_rx,
   output logic                 tx_mclk,
   output logic                 rx_mclk,
   output logic                 mclk_out
);
   logic [SRC_SEL_W-1:0] sel_a  [CHAN_CNT];
   logic [DIV_W-1:0]     div_a  [CHAN_CNT];
   logic [FRAC_W-1:0]    num_a  [CHAN_CNT];
   logic [FRAC_W-1:0]    den_a  [CHAN_CNT];
   logic                 on_a   [CHAN_CNT];
   logic                 mclk_a [CHAN_CNT];

   assign sel_a[0] = tx_src_sel;  assign sel_a[1] = rx_src_sel;
   assign div_a[0] = tx_div_int;  assign div_a[1] = rx_div_int;
   assign num_a[0] = tx_frac_num; assign num_a[1] = rx_frac_num;
   assign den_a[0] = tx_frac_den; assign den_a[1] = rx_frac_den;
   assign on_a[0]  = tx_clk_on;   assign on_a[1]  = rx_clk_on;

   for (genvar c = 0; c < CHAN_CNT; c++) begin : g_chan
      logic                 act_q, tick, adv, long_now;
      logic [DIV_W-1:0]     n_eff;
      logic [SRC_SEL_W-1:0] sel_q;

      always_ff @(posedge clk) begin
         if (!rst_n) act_q <= 1'b0;
         else        act_q <= on_a[c];
      end

      mclk_tick_mux #(.SEL_W(SRC_SEL_W), .NUM_SRC(SRC_COUNT)) i_mux (
         .src_tick (src_tick),
         .sel      (sel_q),
         .tick     (tick)
      );

      mclk_frac_seq #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .SEL_W(SRC_SEL_W)) i_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (!act_q),
         .adv      (adv),
         .n_in     (div_a[c]),
         .num_in   (num_a[c]),
         .den_in   (den_a[c]),
         .sel_in   (sel_a[c]),
         .n_eff    (n_eff),
         .long_now (long_now),
         .sel_q    (sel_q)
      );

      mclk_period_gen #(.DIV_W(DIV_W)) i_gen (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (act_q),
         .tick     (tick),
         .n_eff    (n_eff),
         .long_now (long_now),
         .adv      (adv),
         .mclk     (mclk_a[c])
      );

      // R7: a channel switched off is low one cycle later
      a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
         !on_a[c] |=> !mclk_a[c]);
   end

   assign tx_mclk  = mclk_a[0];
   assign rx_mclk  = mclk_a[1];
   assign mclk_out = mclk_use_rx ? mclk_a[1] : mclk_a[0];
endmodule

// File: tb/test_mclk_frac_div.sv
`timescale 1ns/1ps
module test_mclk_frac_div;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] src_tick;
   logic [1:0] tx_src_sel, rx_src_sel;
   logic [7:0] tx_div_int, rx_div_int;
   logic [5:0] tx_frac_num, tx_frac_den, rx_frac_num, rx_frac_den;
   logic       tx_clk_on, rx_clk_on, mclk_use_rx;
   logic       tx_mclk, rx_mclk, mclk_out;

   always #2 clk = ~clk;   // 250 MHz

   mclk_frac_div i_mclk_frac_div (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
      .tx_src_sel(tx_src_sel), .tx_div_int(tx_div_int),
      .tx_frac_num(tx_frac_num), .tx_frac_den(tx_frac_den), .tx_clk_on(tx_clk_on),
      .rx_src_sel(rx_src_sel), .rx_div_int(rx_div_int),
      .rx_frac_num(rx_frac_num), .rx_frac_den(rx_frac_den), .rx_clk_on(rx_clk_on),
      .mclk_use_rx(mclk_use_rx), .tx_mclk(tx_mclk), .rx_mclk(rx_mclk), .mclk_out(mclk_out)
   );

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   int q_per[$];
   int q_hi[$];
   string q_tag[$];

   // source s pulses once every s+1 cycles
   always @(negedge clk) begin
      cyc++;
      src_tick[0] = 1'b1;
      src_tick[1] = (cyc % 2) == 0;
      src_tick[2] = (cyc % 3) == 0;
      src_tick[3] = (cyc % 4) == 0;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   // monitor: measures periods on mclk_out; the first period after enable is skipped
   bit mon_on = 0;
   logic prev = 1'b0;
   int rises = 0, t_start = 0, hi_acc = 0;
   always @(negedge clk) begin
      if (!mon_on) begin
         rises = 0;
      end else begin
         if (mclk_out && !prev) begin
            if (rises >= 2 && q_per.size() != 0) begin
               int p, h;
               string t;
               p = q_per.pop_front();
               h = q_hi.pop_front();
               t = q_tag.pop_front();
               compared++;
               if ((cyc - t_start) != p || hi_acc != h) begin
                  mismatched++;
                  $display("FAIL %s: period %0d high %0d, expected period %0d high %0d",
                           t, cyc - t_start, hi_acc, p, h);
               end
            end
            rises++;
            t_start = cyc;
            hi_acc = 0;
         end
         if (mclk_out) hi_acc++;
      end
      prev = mclk_out;
   end

   // expected period lengths, built from the requirement text
   task automatic push_run(input int n, input int num, input int den, input int k,
                           input int runs, input bit skip, input string tag);
      int ne, lens[$];
      ne = (n < 2) ? 2 : n;
      for (int r = 0; r < runs; r++) begin
         if (num == 0 || den == 0 || num >= den) begin
            lens.push_back(ne);
         end else if (2 * num <= den) begin
            int x, y;
            x = (den - num) / num;
            y = den - num * (x + 1);
            for (int g = 0; g < num; g++) begin
               for (int i = 0; i < x; i++) lens.push_back(ne);
               lens.push_back(ne + 1);
            end
            for (int i = 0; i < y; i++) lens.push_back(ne);
         end else begin
            int c, x, y;
            c = den - num;
            x = num / c;
            y = den - c * (x + 1);
            for (int g = 0; g < c; g++) begin
               lens.push_back(ne);
               for (int i = 0; i < x; i++) lens.push_back(ne + 1);
            end
            for (int i = 0; i < y; i++) lens.push_back(ne + 1);
         end
      end
      if (skip) void'(lens.pop_front());
      foreach (lens[i]) begin
         q_per.push_back(lens[i] * k);
         q_hi.push_back((lens[i] / 2) * k);
         q_tag.push_back(tag);
      end
   endtask

   task automatic set_chan(input int ch, input int sel, input int n, input int num, input int den);
      if (ch == 0) begin
         tx_src_sel = 2'(sel); tx_div_int = 8'(n); tx_frac_num = 6'(num); tx_frac_den = 6'(den);
      end else begin
         rx_src_sel = 2'(sel); rx_div_int = 8'(n); rx_frac_num = 6'(num); rx_frac_den = 6'(den);
      end
   endtask

   task automatic wait_drain();
      while (q_per.size() != 0) @(negedge clk);
   endtask

   task automatic stop_all();
      tx_clk_on = 1'b0;
      rx_clk_on = 1'b0;
      repeat (4) @(negedge clk);
      mon_on = 0;
      repeat (2) @(negedge clk);
   endtask

   // the other channel runs an unrelated divide at the same time (R10)
   task automatic run_case(input string tag, input int ch, input int sel, input int n,
                           input int num, input int den, input int runs);
      @(negedge clk);
      set_chan(ch, sel, n, num, den);
      set_chan(1 - ch, 0, 7, 0, 0);
      mclk_use_rx = (ch == 1);
      mon_on = 1;
      if (ch == 0) begin tx_clk_on = 1'b1; rx_clk_on = 1'b1; end
      else         begin rx_clk_on = 1'b1; tx_clk_on = 1'b1; end
      push_run(n, num, den, sel + 1, runs, 1'b1, tag);
      wait_drain();
      stop_all();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run did not finish, got %0d, expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int ones;
      rst_n = 1'b0;
      src_tick = '0;
      tx_clk_on = 1'b0; rx_clk_on = 1'b0; mclk_use_rx = 1'b0;
      set_chan(0, 0, 0, 0, 0);
      set_chan(1, 0, 0, 0, 0);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(tx_mclk == 0 && rx_mclk == 0 && mclk_out == 0, "R7 reset outputs low",
          {tx_mclk, rx_mclk, mclk_out}, 0);

      run_case("R2 integer N=5",          0, 0, 5, 0, 0, 6);
      run_case("R2 N=1 acts as 2",        0, 0, 1, 0, 0, 6);
      run_case("R2 N=0 a=0 acts as 2",    0, 0, 0, 3, 0, 6);
      run_case("R2 b>=a integer",         0, 0, 4, 5, 5, 6);
      run_case("R3 R4 b=2 a=5",           0, 0, 4, 2, 5, 3);
      run_case("R4 b=1 a=4",              0, 0, 3, 1, 4, 3);
      run_case("R4 half b=3 a=6",         0, 0, 5, 3, 6, 3);
      run_case("R5 b=4 a=5",              0, 0, 2, 4, 5, 3);
      run_case("R5 b=3 a=5",              0, 0, 7, 3, 5, 3);
      run_case("R5 R6 N=255 b=7 a=9",     0, 0, 255, 7, 9, 1);
      run_case("R1 fast PLL source",      0, 1, 3, 0, 0, 5);
      run_case("R1 slow PLL source",      0, 2, 3, 1, 2, 3);
      run_case("R1 external source",      0, 3, 3, 0, 0, 5);
      run_case("R9 R10 rx fractional",    1, 0, 6, 5, 7, 2);
      run_case("R10 rx slow source",      1, 2, 2, 1, 3, 3);

      // R8: a change made during the last old run waits for the next run
      @(negedge clk);
      set_chan(0, 0, 4, 2, 5);
      mclk_use_rx = 1'b0;
      mon_on = 1;
      tx_clk_on = 1'b1;
      push_run(4, 2, 5, 1, 2, 1'b1, "R8 old run kept");
      while (q_per.size() > 5) @(negedge clk);
      set_chan(0, 0, 3, 2, 3);
      push_run(3, 2, 3, 1, 2, 1'b0, "R8 new run applied");
      wait_drain();
      stop_all();

      // R7: disable holds the output low, enable restarts with a high phase
      @(negedge clk);
      set_chan(0, 0, 6, 0, 0);
      tx_clk_on = 1'b1;
      repeat (9) @(negedge clk);
      tx_clk_on = 1'b0;
      @(negedge clk);
      ones = 0;
      for (int i = 0; i < 20; i++) begin
         if (mclk_out) ones++;
         @(negedge clk);
      end
      chk(ones == 0, "R7 disabled output held low", ones, 0);
      tx_clk_on = 1'b1;
      @(negedge clk);
      chk(mclk_out == 1'b1, "R7 restart begins high", mclk_out, 1);
      repeat (2) @(negedge clk);
      chk(mclk_out == 1'b1, "R7 restart high for N/2", mclk_out, 1);
      @(negedge clk);
      chk(mclk_out == 1'b0, "R7 restart low after N/2", mclk_out, 0);

      // R9: route follows the select, with the two channels dividing differently
      set_chan(1, 0, 5, 0, 0);
      rx_clk_on = 1'b1;
      set_chan(0, 0, 3, 0, 0);
      mclk_use_rx = 1'b1;
      @(negedge clk);
      ones = 0;
      for (int i = 0; i < 40; i++) begin
         if (mclk_out != rx_mclk) ones++;
         @(negedge clk);
      end
      chk(ones == 0, "R9 route select 1 follows receive", ones, 0);
      mclk_use_rx = 1'b0;
      @(negedge clk);
      ones = 0;
      for (int i = 0; i < 40; i++) begin
         if (mclk_out != tx_mclk) ones++;
         @(negedge clk);
      end
      chk(ones == 0, "R9 route select 0 follows transmit", ones, 0);
      stop_all();

      finish_run();
   end
endmodule